// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

The block adds two 16-bit operands and a carry input. Each operand bit pair forms a generate term (both bits set) and a propagate term (either bit set). Four 4-bit slices each resolve their internal carries as flat sums of products, with no rippling. Each slice also reports a slice generate and a slice propagate. A second-level lookahead unit takes these slice terms and the carry input and forms the carry entering every slice at the same time. The same unit also forms the final carry out.

The sum, the carry out and the whole-word generate and propagate terms are registered once. Every result therefore appears one clock after its operands, and a new operand pair can be accepted on every cycle. The whole-word generate and propagate let a wider adder place several of these units under a further lookahead level.

Top module: `gcla_adder`

## Requirements
- R1: While the synchronous active-high reset is sampled high on a rising edge, the sum, carry out, generate and propagate outputs are all 0 after that edge, whatever the operands.
- R2: After a rising edge with reset low, the sum output equals (op_a + op_b + carry_in) modulo 2^16 for the values sampled at that edge. A new operand set is taken on every edge.
- R3: After the same edge, the carry out equals bit 16 of the 17-bit sum op_a + op_b + carry_in.
- R4: The propagate output is 1 exactly when every bit position has at least one operand bit set, that is, when (op_a | op_b) is all ones.
- R5: The generate output is 1 exactly when op_a + op_b, with no carry in, is 2^16 or more.
- R6: The carry out equals generate OR (propagate AND carry_in), and it agrees with the carry leaving the topmost slice.
- R7: A carry input crosses all four slices within the same cycle. Two cases show this: 0xFFFF + 0x0000 + 1 gives sum 0x0000 with carry out 1, and 0x0F0F + 0xF0F0 + 1 gives sum 0x0000 with carry out 1 and generate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Registered sum |
| carry_out | output | 1 | Registered carry out of bit 15 |
| word_gen | output | 1 | Registered whole-word generate |
| word_prop | output | 1 | Registered whole-word propagate |

## Verification
The properties compare each registered output with the operands of the previous edge. They assume the operands and the carry input are known (not X) at every sampling edge once reset has ended. They also assume reset lasts at least one edge before any comparison starts. The stimulus meets these assumptions. Every input changes only on falling edges, from fully defined constants or random words, and reset is released only after the held-reset check. The operands cover the full-propagate and full-generate patterns as well as random words.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
  localparam int unsigned DEF_SLICE_W = 4;
  localparam int unsigned DEF_SLICES  = 4;
endpackage

// File: rtl/gcla_bit_terms.sv
module gcla_bit_terms #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = x[i] & y[i];
    assign prop[i] = x[i] | y[i];
  end
endmodule

// File: rtl/gcla_lookahead.sv
module gcla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         grp_gen,
  output logic         grp_prop
);
  // Each carry is a flat OR of AND terms, expanded from cin.
  always_comb begin
    logic acc;
    logic term;
    carry    = '0;
    carry[0] = cin;
    for (int j = 1; j <= int'(N); j++) begin
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = gen[k];
        for (int m = k + 1; m < j; m++) term = term & prop[m];
        acc = acc | term;
      end
      term = cin;
      for (int m = 0; m < j; m++) term = term & prop[m];
      carry[j] = acc | term;
    end
  end

  always_comb begin
    logic term;
    grp_gen = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      term = gen[k];
      for (int m = k + 1; m < int'(N); m++) term = term & prop[m];
      grp_gen = grp_gen | term;
    end
    grp_prop = &prop;
  end
endmodule

// File: rtl/gcla_slice.sv
module gcla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         sl_gen,
  output logic         sl_prop
);
  logic [W-1:0] gen, prop;
  logic [W:0]   carry;

  gcla_bit_terms #(.W(W)) u_terms (
    .x(x), .y(y), .gen(gen), .prop(prop)
  );

  gcla_lookahead #(.N(W)) u_la (
    .gen(gen), .prop(prop), .cin(cin),
    .carry(carry), .grp_gen(sl_gen), .grp_prop(sl_prop)
  );

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign sum[i] = x[i] ^ y[i] ^ carry[i];
  end
  assign cout = carry[W];
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder
  import gcla_pkg::*;
#(
  parameter int unsigned SLICE_W = DEF_SLICE_W,
  parameter int unsigned SLICES  = DEF_SLICES,
  localparam int unsigned WIDTH  = SLICE_W * SLICES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             word_gen,
  output logic             word_prop
);
  logic [SLICES-1:0] sl_gen, sl_prop, sl_cout;
  logic [SLICES:0]   sl_carry;
  logic [WIDTH-1:0]  sum_c;
  logic              wgen_c, wprop_c;

  gcla_lookahead #(.N(SLICES)) u_level2 (
    .gen(sl_gen), .prop(sl_prop), .cin(carry_in),
    .carry(sl_carry), .grp_gen(wgen_c), .grp_prop(wprop_c)
  );

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    gcla_slice #(.W(SLICE_W)) u_slice (
      .x      (op_a[s*SLICE_W +: SLICE_W]),
      .y      (op_b[s*SLICE_W +: SLICE_W]),
      .cin    (sl_carry[s]),
      .sum    (sum_c[s*SLICE_W +: SLICE_W]),
      .cout   (sl_cout[s]),
      .sl_gen (sl_gen[s]),
      .sl_prop(sl_prop[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      carry_out <= 1'b0;
      word_gen  <= 1'b0;
      word_prop <= 1'b0;
    end else begin
      sum_out   <= sum_c;
      carry_out <= sl_carry[SLICES];
      word_gen  <= wgen_c;
      word_prop <= wprop_c;
    end
  end
endmodule

// File: rtl/gcla_adder_chk.sv
module gcla_adder_chk #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SLICES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out,
  input logic             word_gen,
  input logic             word_prop,
  input logic [SLICES-1:0] sl_cout
);
  logic armed, rst_q;
  logic [WIDTH:0] full_sum, bare_sum;

  assign full_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
  assign bare_sum = {1'b0, op_a} + {1'b0, op_b};

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      p_reset_clear_r1: assert (sum_out == '0 && !carry_out && !word_gen && !word_prop);
    end
  end

  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> sum_out == $past(full_sum[WIDTH-1:0]));

  p_cout_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> carry_out == $past(full_sum[WIDTH]));

  p_prop_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> word_prop == $past(&(op_a | op_b)));

  p_gen_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> word_gen == $past(bare_sum[WIDTH]));

  p_top_slice_r6: assert property (@(posedge clk) disable iff (rst)
    armed |-> carry_out == $past(sl_cout[SLICES-1]));
endmodule

bind gcla_adder gcla_adder_chk #(.WIDTH(WIDTH), .SLICES(SLICES)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum_out(sum_out), .carry_out(carry_out), .word_gen(word_gen),
  .word_prop(word_prop), .sl_cout(sl_cout)
);

// File: tb/gcla_adder_bench.sv
module gcla_adder_bench;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] sum;
    logic         cout;
    logic         gen;
    logic         prop;
    logic         cin;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum_out;
  logic         carry_out, word_gen, word_prop;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  gcla_adder u_gcla_adder (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_out), .carry_out(carry_out), .word_gen(word_gen),
    .word_prop(word_prop)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string tag);
    exp_t e;
    logic [W:0] s;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    e.sum  = s[W-1:0];
    e.cout = s[W];
    s = {1'b0, a} + {1'b0, b};
    e.gen  = s[W];
    e.prop = &(a | b);
    e.cin  = ci;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Monitor: one item becomes visible at each edge after it was driven.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag,     sum_out,                 e.sum);
        check("R3 cout", {15'b0, carry_out},      {15'b0, e.cout});
        check("R4 prop", {15'b0, word_prop},      {15'b0, e.prop});
        check("R5 gen",  {15'b0, word_gen},       {15'b0, e.gen});
        check("R6 cout=gen|prop&cin", {15'b0, carry_out},
              {15'b0, word_gen | (word_prop & e.cin)});
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset held with busy operands
    @(negedge clk);
    op_a = 16'hFFFF; op_b = 16'hFFFF; carry_in = 1'b1;
    @(posedge clk); #1;
    check("R1 sum",  sum_out, '0);
    check("R1 flags", {13'b0, carry_out, word_gen, word_prop}, '0);
    @(negedge clk);
    rst = 1'b0;
    op_a = '0; op_b = '0; carry_in = 1'b0;

    drive(16'h0000, 16'h0000, 1'b0, "R2 zero");
    drive(16'hFFFF, 16'h0000, 1'b1, "R7 ffff+0+1");
    drive(16'h0F0F, 16'hF0F0, 1'b1, "R7 0f0f+f0f0+1");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 all ones+cin");
    drive(16'h8000, 16'h8000, 1'b0, "R3 msb carry");
    drive(16'h0FFF, 16'h0001, 1'b0, "R2 cross three slices");
    drive(16'h1234, 16'h4321, 1'b0, "R2 no carry");
    drive(16'h00FF, 16'hFF00, 1'b0, "R4 prop no cin");
    for (int i = 0; i < 2000; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R2 random");
    end
    @(negedge clk);
    @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2 actual=%0d expected=0 pending results", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule